// File: doc/BRIEF.md
# UART Interrupt Mask and Cause Controller

This block collects the interrupt sources of a serial port into one sticky cause register and drives a single level interrupt request. Five inputs are live FIFO levels: receive trigger, receive empty, receive full, transmit empty and transmit full. Whenever one of them is high, its cause bit is set, and the bit stays set after the level drops. Five further inputs are single-cycle event pulses: receive overrun, framing error, parity error, receive timeout and modem-status change. Each pulse also sets its own cause bit.

Software reaches the block through a word-addressed register bus with a write strobe, a read strobe, an address and 32-bit data. The interrupt mask can only be changed through two registers. One sets mask bits and the other clears them. The mask itself can be read but not written. The cause register is cleared by writing ones to the bits to clear. The interrupt line is a registered OR over the bitwise AND of mask and cause.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the mask, the cause register and `irq_o` are all zero.
- R2: The bit layout of the cause register is as follows. Bits 0 to 4 follow `fifo_lvl_i[0..4]`: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full. A cause bit is set at the first clock edge on which its level input is high, and it stays set after the input falls.
- R3: A one-cycle pulse on `event_i[k]` sets cause bit 5+k at that clock edge. The event bits are: 5 overrun, 6 framing error, 7 parity error, 8 receive timeout, 9 modem-status change.
- R4: A write to the mask-set register (word address 3) ORs `wdata_i[9:0]` into the mask.
- R5: A write to the mask-clear register (word address 4) clears every mask bit written as one and leaves the others unchanged.
- R6: The mask register (word address 2) is read-only, and a write to it leaves the mask unchanged.
- R7: A write to the cause register (word address 1) clears each cause bit written as one. Bits written as zero keep their value.
- R8: `irq_o` is the OR of mask AND cause, registered. It changes one clock edge after the mask or the cause changes.
- R9: If a cause clear and a set from a level or an event hit the same bit in the same cycle, the bit ends up set.
- R10: The status register (word address 0) shows the live levels in bits 4..0 and `aux_lvl_i` in bits 12..10 (receiver active, transmitter active, flow delay). Bits 12..10 never affect the cause register.
- R11: A read strobe loads `rdata_o` at that clock edge with the addressed register, with unused bits reading zero. The mask-set register, the mask-clear register and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| fifo_lvl_i | input | 5 | Live FIFO status levels (cause bits 4..0) |
| event_i | input | 5 | Event pulses (cause bits 9..5) |
| aux_lvl_i | input | 3 | Status-only levels (status bits 12..10) |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench covers the following corner cases:
- Stickiness: a level pulse lasting one cycle must still be visible in the cause register later. A design that mirrors the level would read back zero.
- Mask writes: an OR into the mask is checked next to a partial clear. A write to the read-only mask address is also checked, and a design that stores it would show a changed mask.
- Clear against set: a cause clear is issued in the same cycle as an event on the same bit. A design where the clear wins would lose that interrupt.
- Interrupt timing: `irq_o` is sampled both before and after the register stage, so a combinational or two-stage output shows up as wrong at one of the two samples.
- Status-only bits: the status-only levels are raised, and the cause register must stay unchanged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned LVL_N    = 5;
  localparam int unsigned EVT_N    = 5;
  localparam int unsigned AUX_N    = 3;
  localparam int unsigned CAUSE_W  = LVL_N + EVT_N;
  localparam int unsigned AUX_LSB  = 10;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS   = 3'd0,
    REG_CAUSE    = 3'd1,
    REG_MASK     = 3'd2,
    REG_MASK_SET = 3'd3,
    REG_MASK_CLR = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (set_we_i) mask_q <= mask_q | wdata_i;
    else if (clr_we_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;

  a_r4_set_ors: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
  a_r5_clr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && !set_we_i |=> ((mask_o & $past(wdata_i)) == '0));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_we_i && !clr_we_i |=> $stable(mask_o));
endmodule

// File: rtl/uart_irq_cause.sv
module uart_irq_cause #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;
  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_bits_i : '0;

  // set dominates clear so a same-cycle event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & ~clr_mask) | src_i;
  end

  assign cause_o = cause_q;

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_o & $past(src_i)) == $past(src_i)));
  a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((cause_o & $past(clr_bits_i & ~src_i)) == '0));
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LVL_N-1:0]   lvl_i,
  input  logic [AUX_N-1:0]   aux_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CAUSE_W-1:0] mask_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] rd_d, rdata_q, status_w;

  always_comb begin
    status_w = '0;
    status_w[LVL_N-1:0] = lvl_i;
    status_w[AUX_LSB +: AUX_N] = aux_i;
  end

  always_comb begin
    rd_d = '0;
    case (addr_i)
      REG_STATUS: rd_d = status_w;
      REG_CAUSE:  rd_d[CAUSE_W-1:0] = cause_i;
      REG_MASK:   rd_d[CAUSE_W-1:0] = mask_i;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic [LVL_N-1:0]       fifo_lvl_i,
  input  logic [EVT_N-1:0]       event_i,
  input  logic [AUX_N-1:0]       aux_lvl_i,
  output logic                   irq_o
);
  logic               set_we, clr_we, cause_we;
  logic [CAUSE_W-1:0] mask_w, cause_w, src_w;
  logic               irq_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CAUSE_W];

  assign set_we   = wr_en_i && (addr_i == REG_MASK_SET);
  assign clr_we   = wr_en_i && (addr_i == REG_MASK_CLR);
  assign cause_we = wr_en_i && (addr_i == REG_CAUSE);
  assign src_w    = {event_i, fifo_lvl_i};

  uart_irq_mask #(.W(CAUSE_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (set_we),
    .clr_we_i (clr_we),
    .wdata_i  (wdata_i[CAUSE_W-1:0]),
    .mask_o   (mask_w)
  );

  uart_irq_cause #(.W(CAUSE_W)) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_w),
    .clr_we_i   (cause_we),
    .clr_bits_i (wdata_i[CAUSE_W-1:0]),
    .cause_o    (cause_w)
  );

  uart_irq_rdmux u_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .lvl_i   (fifo_lvl_i),
    .aux_i   (aux_lvl_i),
    .cause_i (cause_w),
    .mask_i  (mask_w),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(mask_w & cause_w);
  end

  assign irq_o = irq_q;

  a_r8_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(mask_w) & $past(cause_w))));
  a_r6_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == REG_MASK) |=> $stable(mask_w));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  lvl = '0, evt = '0;
  logic [2:0]  aux = '0;
  logic        irq;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .fifo_lvl_i(lvl), .event_i(evt), .aux_lvl_i(aux), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_CYCLES) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG_CYCLES);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(3'd2, v); check("R1 mask", v, 32'h0);
    rd(3'd1, v); check("R1 cause", v, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    @(negedge clk); lvl = 5'b00100;
    @(negedge clk); lvl = '0;
    rd(3'd1, v); check("R2 level latched", v, 32'h004);
    repeat (3) @(negedge clk);
    rd(3'd1, v); check("R2 sticky after fall", v, 32'h004);
  endtask

  task automatic t_events();
    logic [31:0] v;
    @(negedge clk); evt = 5'b00010;
    @(negedge clk); evt = '0;
    rd(3'd1, v); check("R3 framing event bit6", v, 32'h044);
    @(negedge clk); aux = 3'b111; lvl = 5'b00000;
    rd(3'd0, v); check("R10 status aux bits", v, 32'h1C00);
    rd(3'd1, v); check("R10 aux not in cause", v, 32'h044);
    aux = '0;
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd3, 32'h005);
    rd(3'd2, v); check("R4 set", v, 32'h005);
    wr(3'd3, 32'h0C0);
    rd(3'd2, v); check("R4 or into mask", v, 32'h0C5);
    wr(3'd4, 32'h004);
    rd(3'd2, v); check("R5 clear ones", v, 32'h0C1);
    wr(3'd2, 32'h3FF);
    rd(3'd2, v); check("R6 read-only mask", v, 32'h0C1);
    rd(3'd3, v); check("R11 set reg reads zero", v, 32'h0);
    rd(3'd7, v); check("R11 unmapped reads zero", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    check("R8 irq asserted", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h040);
    check("R8 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);
    rd(3'd1, v); check("R7 zero bits kept", v, 32'h004);
    wr(3'd1, 32'h004);
    rd(3'd1, v); check("R7 cleared", v, 32'h0);
    @(negedge clk); lvl = 5'b00001;
    @(negedge clk); lvl = '0;
    check("R8 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq one edge later", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk); wr_en = 1'b1; addr = 3'd1; wdata = 32'h3FF; evt = 5'b10000;
    @(negedge clk); wr_en = 1'b0; wdata = '0; evt = '0;
    rd(3'd1, v); check("R9 set wins over clear", v, 32'h200);
    @(negedge clk);
    check("R8 irq off when unmasked", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sticky();
    t_events();
    t_mask();
    t_irq();
    t_collide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule